// File: doc/BRIEF.md
# Serial Receive Channel with Sticky Status Flags

This block is the receive half of an asynchronous serial port. It watches a single serial input line that it oversamples on a tick strobe running at sixteen times the bit rate. From that line it builds frames of one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Each completed byte goes into a data register, and a status register reports what happened to it. An interrupt pulse goes out each time a new byte becomes available.

Software reaches the block through a small register bus with three registers: data, status and control. A DMA-style agent can also collect the byte with its own read strobe, and that read clears the data-full flag by itself. Any error flag stops the receiver until software clears every error flag. The status register also shows the present level of the serial line, so software can tell a held-low break from a single bad frame.

Received bytes leave the block only through register reads or the DMA strobe. There is no valid/ready stream at either edge and no back-pressure. If a byte is not collected in time, the next completed frame is lost and an overrun is recorded.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x00, status bits 3:0 read 0 and `irq` is low.
- R2: With enable set (control bit 0) and parity off, a frame with eight data bits LSB first and a high stop bit puts its byte in the data register (address 0) and sets the full flag (status bit 0, status at address 1).
- R3: With parity on (control bit 1), control bit 2 picks the parity sense: 0 for even, 1 for odd. A parity bit that matches sets the full flag. A parity bit that does not match writes the byte anyway, leaves the full flag clear and sets the parity flag (status bit 2).
- R4: A stop bit sampled low writes the byte, leaves the full flag clear and sets the framing flag (status bit 3).
- R5: Each time the full flag goes from 0 to 1, `irq` is high for exactly one clock cycle.
- R6: A status flag clears on a status write whose bit for that flag is 0, and only if a status read has returned that flag as 1 since it was last set. A write of 0 with no such read does nothing, and writing 1 never changes a flag.
- R7: A cycle with `dma_rd` high puts the data register on `bus_rdata` and clears the full flag, with no status write.
- R8: A frame that finishes while the full flag is set is thrown away. The data register keeps its old byte and the overrun flag (status bit 1) is set.
- R9: While the overrun, parity or framing flag is set, no frame is received and no register changes. Reception starts again once all three are clear.
- R10: With the enable bit clear, a frame on the line leaves the data and status registers unchanged.
- R11: Status bit 7 gives the level of `rxd` two clock cycles after the line changes.
- R12: A low pulse on the line that ends before the middle of the start bit is rejected and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Single-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| dma_rd | input | 1 | DMA read of the data register; clears the full flag |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing on status) |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | One-cycle receive interrupt pulse |

## Verification
The hardest case to reach is the frozen receiver. Getting there takes an overrun, then a third frame sent while the overrun flag is set, which must leave no trace. After that the flags are cleared by a status read followed by a write of zero, and the block must then receive again. The directed stimulus leaves a good byte uncollected on purpose, sends two more frames behind it, and checks the data register, the status bits and the interrupt count after each frame. The read-before-clear rule is tested in the same way: first a bare write of zero, then a write of ones, then the correct read-and-write sequence.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam int F_FULL = 0;
  localparam int F_OVR  = 1;
  localparam int F_PAR  = 2;
  localparam int F_FRM  = 3;
  localparam int NFLAGS = 4;

  localparam int C_EN   = 0;
  localparam int C_PEN  = 1;
  localparam int C_PODD = 2;
  localparam int CTRL_W = 3;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              line,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_err,
  output logic              stop_err,
  output logic              busy
);
  localparam int CW = $clog2(OS_RATE);
  localparam int IW = $clog2(DATA_W);
  localparam logic [CW-1:0] MID  = CW'(OS_RATE / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);
  localparam logic [IW-1:0] TOP  = IW'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              pbit_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      pbit_q  <= 1'b0;
      prev_q  <= 1'b1;
    end else if (!run) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      prev_q  <= 1'b1;
    end else if (tick) begin
      prev_q <= line;
      case (state_q)
        S_IDLE: if (prev_q && !line) begin
          state_q <= S_START;
          cnt_q   <= '0;
        end
        S_START: if (cnt_q == MID) begin
          cnt_q   <= '0;
          idx_q   <= '0;
          state_q <= line ? S_IDLE : S_DATA;
        end else cnt_q <= cnt_q + 1'b1;
        S_DATA: if (cnt_q == LAST) begin
          cnt_q   <= '0;
          shift_q <= {line, shift_q[DATA_W-1:1]};
          idx_q   <= idx_q + 1'b1;
          if (idx_q == TOP) state_q <= par_en ? S_PAR : S_STOP;
        end else cnt_q <= cnt_q + 1'b1;
        S_PAR: if (cnt_q == LAST) begin
          cnt_q   <= '0;
          pbit_q  <= line;
          state_q <= S_STOP;
        end else cnt_q <= cnt_q + 1'b1;
        S_STOP: if (cnt_q == LAST) begin
          cnt_q   <= '0;
          state_q <= S_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done     = run && tick && (state_q == S_STOP) && (cnt_q == LAST);
  assign data     = shift_q;
  assign par_err  = par_en && (pbit_q != ((^shift_q) ^ par_odd));
  assign stop_err = !line;
  assign busy     = (state_q != S_IDLE);
endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_rd,
  input  logic              done,
  input  logic [DATA_W-1:0] fdata,
  input  logic              fpar_err,
  input  logic              fstop_err,
  input  logic              line,
  output logic [DATA_W-1:0] data_q,
  output logic [NFLAGS-1:0] flag_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              irq
);
  logic [NFLAGS-1:0] armed_q, set_v, clr_v;
  logic rd_stat, wr_stat, wr_ctrl;
  logic unused_wbits;

  assign rd_stat = bus_sel && bus_rd && (bus_addr == A_STAT);
  assign wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign unused_wbits = ^bus_wdata[DATA_W-1:NFLAGS];

  always_comb begin
    set_v = '0;
    if (done) begin
      if (flag_q[F_FULL])            set_v[F_OVR] = 1'b1;
      else if (fpar_err || fstop_err) begin
        set_v[F_PAR] = fpar_err;
        set_v[F_FRM] = fstop_err;
      end else                       set_v[F_FULL] = 1'b1;
    end
    for (int i = 0; i < NFLAGS; i++)
      clr_v[i] = wr_stat && !bus_wdata[i] && armed_q[i];
    clr_v[F_FULL] = clr_v[F_FULL] || dma_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      for (int i = 0; i < NFLAGS; i++) begin
        if (set_v[i]) begin
          flag_q[i]  <= 1'b1;
          armed_q[i] <= 1'b0;
        end else if (clr_v[i]) begin
          flag_q[i]  <= 1'b0;
          armed_q[i] <= 1'b0;
        end else if (rd_stat && flag_q[i]) begin
          armed_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (done && !flag_q[F_FULL]) data_q <= fdata;
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      irq <= set_v[F_FULL];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (dma_rd) bus_rdata = data_q;
    else begin
      case (bus_addr)
        A_DATA: bus_rdata = data_q;
        A_STAT: begin
          bus_rdata[NFLAGS-1:0] = flag_q;
          bus_rdata[DATA_W-1]   = line;
        end
        A_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat
  import uart_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        os_tick,
  input  logic        rxd,
  input  logic        dma_rd,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq
);
  logic              line_s, run;
  logic              f_done, f_perr, f_ferr, f_busy;
  logic [DATA_W-1:0] f_data, rx_data;
  logic [NFLAGS-1:0] flags;
  logic [CTRL_W-1:0] ctrl_q;

  assign run = ctrl_q[C_EN] && !(flags[F_OVR] || flags[F_PAR] || flags[F_FRM]);

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(os_tick), .line(line_s),
    .par_en(ctrl_q[C_PEN]), .par_odd(ctrl_q[C_PODD]),
    .done(f_done), .data(f_data), .par_err(f_perr), .stop_err(f_ferr),
    .busy(f_busy)
  );

  uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_rd(dma_rd), .done(f_done), .fdata(f_data),
    .fpar_err(f_perr), .fstop_err(f_ferr), .line(line_s),
    .data_q(rx_data), .flag_q(flags), .ctrl_q(ctrl_q), .irq(irq)
  );
endmodule

// File: rtl/uart_rx_stat_chk.sv
module uart_rx_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       busy,
  input logic       done,
  input logic       full,
  input logic       ovr,
  input logic       perr,
  input logic       ferr,
  input logic       irq,
  input logic [7:0] data_q,
  input logic       st_wr,
  input logic       dma_rd
);
  // R5: a new byte raises the interrupt
  a_r5_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> irq);
  // R5: interrupt is a single-cycle pulse
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8: overrun keeps the old byte
  a_r8_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(data_q));
  // R9: no frame completes while an error flag is set
  a_r9_frozen_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr || perr || ferr) |-> !done);
  // R10: disabled receiver returns to idle
  a_r10_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  // R6: a status write never sets a flag
  a_r6_write_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !done) |=> !($rose(full) || $rose(ovr) || $rose(perr) || $rose(ferr)));
  // R7: DMA read clears the full flag
  a_r7_dma_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rd && !done) |=> !full);
endmodule

bind uart_rx_stat uart_rx_stat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q[0]), .busy(f_busy), .done(f_done),
  .full(flags[0]), .ovr(flags[1]), .perr(flags[2]), .ferr(flags[3]),
  .irq(irq), .data_q(rx_data),
  .st_wr(bus_sel && bus_wr && (bus_addr == 2'd1)), .dma_rd(dma_rd)
);

// File: tb/sim_uart_rx_stat.sv
module sim_uart_rx_stat;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  // {byte[19:12], par_en[11], par_odd[10], flip_par[9], stop[8], exp_status[7:0]}
  localparam int NV = 7;
  localparam logic [19:0] VEC [NV] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 8'h81},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 8'h81},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 8'h81},
    {8'h7E, 1'b1, 1'b0, 1'b1, 1'b1, 8'h84},
    {8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h84},
    {8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 8'h88},
    {8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h88}
  };

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1, dma_rd = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic irq;
  int n_chk = 0, n_err = 0, irq_cnt = 0, tdiv = 0;

  uart_rx_stat u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .dma_rd(dma_rd),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    tdiv    = (tdiv + 1) % TICK_DIV;
    os_tick = (tdiv == 0);
    if (irq) irq_cnt++;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic dma_read(output logic [7:0] d);
    @(negedge clk); dma_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); dma_rd = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic pen, input logic podd,
                      input logic flip, input logic stop);
    @(negedge clk); rxd = 0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    if (pen) begin
      rxd = (^b) ^ podd ^ flip;
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT_CLKS) @(negedge clk);
    rxd = 1;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic clear_all();
    logic [7:0] d;
    bus_read(2'd1, d);
    bus_write(2'd1, 8'h00);
  endtask

  initial begin
    logic [7:0] d;
    int ic;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {7'd0, irq}, 8'h00);
    bus_read(2'd0, d); check("R1 data", d, 8'h00);
    bus_read(2'd2, d); check("R1 ctrl", d, 8'h00);
    bus_read(2'd1, d); check("R1 status", d, 8'h80);

    // table: R2 plain, R3 parity, R4 framing, R5 irq, R7 dma
    for (int v = 0; v < NV; v++) begin
      logic [19:0] e;
      e  = VEC[v];
      ic = irq_cnt;
      bus_write(2'd2, {5'd0, e[10], e[11], 1'b1});
      send(e[19:12], e[11], e[10], e[9], e[8]);
      bus_read(2'd1, d); check("R2/R3/R4 status", d, e[7:0]);
      bus_read(2'd0, d); check("R2/R3/R4 data", d, e[19:12]);
      check("R5 irq count", 8'(irq_cnt - ic), {7'd0, e[0]});
      if (e[0]) begin
        dma_read(d); check("R7 dma data", d, e[19:12]);
      end else clear_all();
      bus_read(2'd1, d); check("R7/R6 cleared", d, 8'h80);
    end

    // R6 read-before-clear rule
    bus_write(2'd2, 8'h01);
    send(8'h11, 0, 0, 0, 1);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); check("R6 unarmed write", d, 8'h81);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, d); check("R6 write one", d, 8'h81);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); check("R6 armed clear", d, 8'h80);

    // R8 overrun, R9 frozen receiver
    ic = irq_cnt;
    send(8'h22, 0, 0, 0, 1);
    send(8'h33, 0, 0, 0, 1);
    bus_read(2'd0, d); check("R8 data kept", d, 8'h22);
    bus_read(2'd1, d); check("R8 status", d, 8'h83);
    send(8'h44, 0, 0, 1, 0);
    bus_read(2'd0, d); check("R9 data frozen", d, 8'h22);
    bus_read(2'd1, d); check("R9 status frozen", d, 8'h83);
    check("R9 irq count", 8'(irq_cnt - ic), 8'd1);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d); check("R9 flags cleared", d, 8'h80);
    send(8'h55, 0, 0, 0, 1);
    bus_read(2'd0, d); check("R9 resumed data", d, 8'h55);
    bus_read(2'd1, d); check("R9 resumed status", d, 8'h81);
    dma_read(d);

    // R10 disabled
    bus_write(2'd2, 8'h00);
    send(8'h66, 0, 0, 0, 1);
    bus_read(2'd0, d); check("R10 data", d, 8'h55);
    bus_read(2'd1, d); check("R10 status", d, 8'h80);

    // R11 line level
    @(negedge clk); rxd = 0;
    repeat (2) @(negedge clk);
    bus_read(2'd1, d); check("R11 line low", d, 8'h00);
    rxd = 1;
    repeat (3) @(negedge clk);
    bus_read(2'd1, d); check("R11 line high", d, 8'h80);

    // R12 false start
    bus_write(2'd2, 8'h01);
    @(negedge clk); rxd = 0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxd = 1;
    repeat (40 * TICK_DIV) @(negedge clk);
    bus_read(2'd1, d); check("R12 glitch rejected", d, 8'h80);
    send(8'h77, 0, 0, 0, 1);
    bus_read(2'd0, d); check("R12 next frame", d, 8'h77);

    summary();
  end
endmodule